// File: doc/BRIEF.md
# Two-Wide Dispatch Stage with Split Register Renaming

This block is the dispatch stage of a dynamically scheduled core that issues up to two instructions per cycle and keeps separate integer and floating-point register sets. Each cycle it is offered an ordered pair of decoded instructions: slot 0 is older, slot 1 is younger. It decides how many of them can leave. An instruction leaves only when a reservation station of its class and a reorder-buffer entry are both free. Slot 1 never leaves without slot 0.

Every instruction that leaves receives a reorder-buffer tag. The tags are handed out in sequence from the current tail position. Each source register is looked up in the rename map of its own register set. The lookup result says either that the value is settled in the register file, or which tag will produce it. When both instructions use the same register set, a source of slot 1 that names the destination of slot 0 is pointed at slot 0's new tag instead of the map entry. An integer/FP pair never needs this cross-check.

The rename maps then record the dispatching instructions as the youngest writers of their destinations. A flush clears both maps. Free counts and the tail tag come from the surrounding pipeline. The dispatch records (fire flags, tags and renamed sources) go out to the reservation stations and the reorder buffer.

Top module: `dual_dispatch`

## Requirements
- R1: After reset, every source lookup in both slots reports ready (value in register file), with source tag 0.
- R2: Slot 0 fires exactly when it is valid, flush is low, `rob_free` is at least 1, and the free count of its class is at least 1. `in_fp` = 1 selects the FP class and `rs_free_fp`; 0 selects integer and `rs_free_int`.
- R3: Slot 1 never fires in a cycle where slot 0 does not fire.
- R4: Slot 1 fires only when `rob_free` is at least 2.
- R5: When both slots are of the same class, slot 1 also needs at least 2 free stations of that class. When the classes differ, slot 1 needs at least 1 of its own class.
- R6: Slot 0's tag equals `rob_tail`. Slot 1's tag equals `rob_tail` + 1, modulo ROB_DEPTH.
- R7: A source whose register has a recorded writer in its own set's map reports not ready, with that writer's tag. Otherwise it reports ready with tag 0.
- R8: Suppose slot 0 is valid, writes a destination, and uses the same register set as slot 1. Then a slot 1 source naming that destination reports not ready, with slot 0's tag, whatever the map holds.
- R9: An integer destination never affects an FP source lookup, and an FP destination never affects an integer source lookup, whether in the same pair or in later cycles.
- R10: When both slots fire, write the same register set and name the same destination, the map afterwards holds slot 1's tag for that register.
- R11: While flush is high, neither slot fires. After the flush cycle, every map entry of both sets reads as ready.
- R12: An instruction that does not fire leaves the maps unchanged.
- R13: An instruction with `in_has_dst` = 0 leaves the maps unchanged when it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears both maps |
| flush | input | 1 | Blocks dispatch and clears both maps at the edge |
| in_valid | input | 2 | Per-slot instruction present (bit 0 = older) |
| in_fp | input | 2 | Per-slot register set: 1 = FP, 0 = integer |
| in_has_dst | input | 2 | Per-slot destination write enable |
| in_dst | input | 2×REG_W | Per-slot destination register |
| in_src_a | input | 2×REG_W | Per-slot first source register |
| in_src_b | input | 2×REG_W | Per-slot second source register |
| rs_free_int | input | RSC_W | Free integer reservation stations |
| rs_free_fp | input | RSC_W | Free FP reservation stations |
| rob_free | input | ROBC_W | Free reorder-buffer entries |
| rob_tail | input | TAG_W | Tag of the next reorder-buffer entry to allocate |
| disp_fire | output | 2 | Per-slot dispatch this cycle |
| disp_tag | output | 2×TAG_W | Per-slot allocated tag |
| disp_a_ready | output | 2 | First source is in the register file |
| disp_a_tag | output | 2×TAG_W | First source producer tag (0 when ready) |
| disp_b_ready | output | 2 | Second source is in the register file |
| disp_b_tag | output | 2×TAG_W | Second source producer tag (0 when ready) |

## Verification
Directed pairs cover four cases: integer/integer, FP/FP, and mixed pairs with matching register indices, and lone slot-0 instructions. Together they separate the intra-pair override from the map lookup and show that the override stays inside one register set. Resource patterns set the free counts just at and just below each threshold, such as one station of a class for a same-class pair and one reorder entry for two instructions. These patterns tell the shared-class rule apart from the per-slot rule, and catch slot 1 overtaking a blocked slot 0. Follow-up lookups after a duplicate-destination pair, a blocked writer, a no-destination writer and a flush show which tag, if any, the map kept. A long random phase with small free counts and a wrapping tail then compares every output against the behavioural model on each cycle.

// File: rtl/dd_pkg.sv
package dd_pkg;

  typedef enum logic {SET_INT = 1'b0, SET_FP = 1'b1} reg_set_e;

  // stations of class want_fp requested by an ordered pair (both counted)
  function automatic logic [1:0] class_need(logic a_fp, logic b_fp, logic want_fp);
    return {1'b0, a_fp == want_fp} + {1'b0, b_fp == want_fp};
  endfunction

  // intra-pair forwarding condition for one younger source
  function automatic logic pair_fwd(logic old_on, logic old_dst_on, logic old_fp,
                                    logic young_fp, logic match);
    return old_on & old_dst_on & (old_fp == young_fp) & match;
  endfunction

endpackage

// File: rtl/dd_rename_map.sv
module dd_rename_map #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 4,
  parameter int RD_PORTS = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             wr0_en,
  input  logic [REG_W-1:0]                 wr0_reg,
  input  logic [TAG_W-1:0]                 wr0_tag,
  input  logic                             wr1_en,
  input  logic [REG_W-1:0]                 wr1_reg,
  input  logic [TAG_W-1:0]                 wr1_tag,
  input  logic [RD_PORTS-1:0][REG_W-1:0]   rd_reg,
  output logic [RD_PORTS-1:0]              rd_busy,
  output logic [RD_PORTS-1:0][TAG_W-1:0]   rd_tag
);

  logic [NUM_REGS-1:0]            busy_q;
  logic [NUM_REGS-1:0][TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy_q <= '0;
      tag_q  <= '0;
    end else begin
      if (wr0_en) begin
        busy_q[wr0_reg] <= 1'b1;
        tag_q[wr0_reg]  <= wr0_tag;
      end
      if (wr1_en) begin  // younger writer overrides
        busy_q[wr1_reg] <= 1'b1;
        tag_q[wr1_reg]  <= wr1_tag;
      end
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_busy[p] = busy_q[rd_reg[p]];
    assign rd_tag[p]  = busy_q[rd_reg[p]] ? tag_q[rd_reg[p]] : '0;
  end

endmodule

// File: rtl/dd_dispatch_gate.sv
module dd_dispatch_gate
  import dd_pkg::*;
#(
  parameter int RSC_W  = 5,
  parameter int ROBC_W = 5
) (
  input  logic              flush,
  input  logic [1:0]        in_valid,
  input  logic [1:0]        in_fp,
  input  logic [RSC_W-1:0]  rs_free_int,
  input  logic [RSC_W-1:0]  rs_free_fp,
  input  logic [ROBC_W-1:0] rob_free,
  output logic [1:0]        fire
);

  logic [RSC_W-1:0] free0, free1;
  logic [1:0]       need1;

  always_comb begin
    free0 = in_fp[0] ? rs_free_fp : rs_free_int;
    free1 = in_fp[1] ? rs_free_fp : rs_free_int;
    need1 = class_need(in_fp[0], in_fp[1], in_fp[1]);
    fire[0] = in_valid[0] & ~flush & (rob_free >= ROBC_W'(1)) & (free0 >= RSC_W'(1));
    fire[1] = fire[0] & in_valid[1] & (rob_free >= ROBC_W'(2))
            & (free1 >= RSC_W'(need1));
  end

endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch
  import dd_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int ROB_DEPTH = 16,
  parameter int RS_MAX    = 16,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int TAG_W    = $clog2(ROB_DEPTH),
  localparam int RSC_W    = $clog2(RS_MAX + 1),
  localparam int ROBC_W   = $clog2(ROB_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [1:0]            in_valid,
  input  logic [1:0]            in_fp,
  input  logic [1:0]            in_has_dst,
  input  logic [1:0][REG_W-1:0] in_dst,
  input  logic [1:0][REG_W-1:0] in_src_a,
  input  logic [1:0][REG_W-1:0] in_src_b,
  input  logic [RSC_W-1:0]      rs_free_int,
  input  logic [RSC_W-1:0]      rs_free_fp,
  input  logic [ROBC_W-1:0]     rob_free,
  input  logic [TAG_W-1:0]      rob_tail,
  output logic [1:0]            disp_fire,
  output logic [1:0][TAG_W-1:0] disp_tag,
  output logic [1:0]            disp_a_ready,
  output logic [1:0][TAG_W-1:0] disp_a_tag,
  output logic [1:0]            disp_b_ready,
  output logic [1:0][TAG_W-1:0] disp_b_tag
);

  localparam int NSETS = 2;
  localparam int NRD   = 4;  // ports: slot0 a, slot0 b, slot1 a, slot1 b

  // named internal events for the checker
  logic [1:0]             fire;
  logic [TAG_W-1:0]       tag0, tag1;
  logic                   pair_same_set;
  logic                   fwd_a1, fwd_b1;

  logic [NRD-1:0][REG_W-1:0]            rd_reg;
  logic [NSETS-1:0][NRD-1:0]            map_busy;
  logic [NSETS-1:0][NRD-1:0][TAG_W-1:0] map_tag;

  dd_dispatch_gate #(.RSC_W(RSC_W), .ROBC_W(ROBC_W)) u_gate (
    .flush(flush), .in_valid(in_valid), .in_fp(in_fp),
    .rs_free_int(rs_free_int), .rs_free_fp(rs_free_fp),
    .rob_free(rob_free), .fire(fire)
  );

  assign tag0          = rob_tail;
  assign tag1          = rob_tail + TAG_W'(1);
  assign pair_same_set = (in_fp[0] == in_fp[1]);
  assign rd_reg        = {in_src_b[1], in_src_a[1], in_src_b[0], in_src_a[0]};

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    dd_rename_map #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .RD_PORTS(NRD)) u_map (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr0_en (fire[0] & in_has_dst[0] & (in_fp[0] == 1'(s))),
      .wr0_reg(in_dst[0]), .wr0_tag(tag0),
      .wr1_en (fire[1] & in_has_dst[1] & (in_fp[1] == 1'(s))),
      .wr1_reg(in_dst[1]), .wr1_tag(tag1),
      .rd_reg (rd_reg), .rd_busy(map_busy[s]), .rd_tag(map_tag[s])
    );
  end

  assign fwd_a1 = pair_fwd(in_valid[0], in_has_dst[0], in_fp[0], in_fp[1],
                           in_src_a[1] == in_dst[0]);
  assign fwd_b1 = pair_fwd(in_valid[0], in_has_dst[0], in_fp[0], in_fp[1],
                           in_src_b[1] == in_dst[0]);

  always_comb begin
    disp_fire = fire;
    disp_tag  = {tag1, tag0};
    // slot 0: map of its own set
    disp_a_ready[0] = ~map_busy[in_fp[0]][0];
    disp_a_tag[0]   = map_tag[in_fp[0]][0];
    disp_b_ready[0] = ~map_busy[in_fp[0]][1];
    disp_b_tag[0]   = map_tag[in_fp[0]][1];
    // slot 1: older slot's new tag beats the map
    disp_a_ready[1] = fwd_a1 ? 1'b0 : ~map_busy[in_fp[1]][2];
    disp_a_tag[1]   = fwd_a1 ? tag0 : map_tag[in_fp[1]][2];
    disp_b_ready[1] = fwd_b1 ? 1'b0 : ~map_busy[in_fp[1]][3];
    disp_b_tag[1]   = fwd_b1 ? tag0 : map_tag[in_fp[1]][3];
  end

endmodule

// File: rtl/dd_dispatch_chk.sv
module dd_dispatch_chk #(
  parameter int REG_W  = 3,
  parameter int TAG_W  = 4,
  parameter int RSC_W  = 5,
  parameter int ROBC_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic [1:0]            in_valid,
  input logic [1:0]            in_fp,
  input logic [1:0]            in_has_dst,
  input logic [1:0][REG_W-1:0] in_dst,
  input logic [1:0][REG_W-1:0] in_src_a,
  input logic [RSC_W-1:0]      rs_free_int,
  input logic [RSC_W-1:0]      rs_free_fp,
  input logic [ROBC_W-1:0]     rob_free,
  input logic [1:0]            disp_fire,
  input logic [1:0][TAG_W-1:0] disp_tag,
  input logic [1:0]            disp_a_ready,
  input logic [1:0][TAG_W-1:0] disp_a_tag,
  input logic [1:0]            disp_b_ready
);

  // R2
  slot0_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire[0] |-> (in_valid[0] && rob_free >= ROBC_W'(1)));

  // R3
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire[1] |-> disp_fire[0]);

  // R4
  rob_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire[1] |-> (rob_free >= ROBC_W'(2)));

  // R5
  shared_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire[1] && in_fp[0] == in_fp[1]) |->
      ((in_fp[1] ? rs_free_fp : rs_free_int) >= RSC_W'(2)));

  // R6
  tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_tag[1] == disp_tag[0] + TAG_W'(1));

  // R8
  pair_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[0] && in_has_dst[0] && in_fp[0] == in_fp[1] && in_src_a[1] == in_dst[0])
      |-> (!disp_a_ready[1] && disp_a_tag[1] == disp_tag[0]));

  // R11
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> disp_fire == 2'b00);

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (disp_a_ready[0] && disp_b_ready[0]));

endmodule

bind dual_dispatch dd_dispatch_chk #(
  .REG_W(REG_W), .TAG_W(TAG_W), .RSC_W(RSC_W), .ROBC_W(ROBC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_fp(in_fp),
  .in_has_dst(in_has_dst), .in_dst(in_dst), .in_src_a(in_src_a),
  .rs_free_int(rs_free_int), .rs_free_fp(rs_free_fp), .rob_free(rob_free),
  .disp_fire(disp_fire), .disp_tag(disp_tag), .disp_a_ready(disp_a_ready),
  .disp_a_tag(disp_a_tag), .disp_b_ready(disp_b_ready)
);

// File: tb/sim_dual_dispatch.sv
`timescale 1ns/1ps
module sim_dual_dispatch;

  localparam int NREG = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [1:0] v = '0, fp = '0, hd = '0;
  logic [1:0][2:0] dst = '0, sa = '0, sb = '0;
  logic [4:0] rsi = 5'd8, rsf = 5'd8, robf = 5'd16;
  logic [3:0] tail = '0;
  logic [1:0] o_fire, o_ar, o_br;
  logic [1:0][3:0] o_tag, o_at, o_bt;

  int n_chk = 0, n_fail = 0;
  string ctx = "";
  int busy[2][NREG];
  int mtag[2][NREG];
  int e_f0, e_f1;

  always #2.5 clk = ~clk;

  dual_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(v), .in_fp(fp),
    .in_has_dst(hd), .in_dst(dst), .in_src_a(sa), .in_src_b(sb),
    .rs_free_int(rsi), .rs_free_fp(rsf), .rob_free(robf), .rob_tail(tail),
    .disp_fire(o_fire), .disp_tag(o_tag), .disp_a_ready(o_ar), .disp_a_tag(o_at),
    .disp_b_ready(o_br), .disp_b_tag(o_bt)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL [%s] %s: got %0d expected %0d", ctx, what, act, exp);
    end
  endtask

  function automatic void exp_src(input int s, input int r, output int rdy, output int tg);
    int st = int'(fp[s]);
    if (s == 1 && v[0] && hd[0] && fp[0] == fp[1] && int'(dst[0]) == r) begin
      rdy = 0; tg = int'(tail);
    end else if (busy[st][r] != 0) begin
      rdy = 0; tg = mtag[st][r];
    end else begin
      rdy = 1; tg = 0;
    end
  endfunction

  function automatic int freeof(input logic f);
    return f ? int'(rsf) : int'(rsi);
  endfunction

  task automatic clear_model();
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < NREG; r++) begin busy[s][r] = 0; mtag[s][r] = 0; end
  endtask

  // called at a negedge with inputs set; compares, then advances one edge
  task automatic cycle();
    int rdy, tg, need;
    #1;
    e_f0 = (v[0] && !flush && robf >= 1 && freeof(fp[0]) >= 1) ? 1 : 0;
    need = (fp[0] == fp[1]) ? 2 : 1;
    e_f1 = (e_f0 == 1 && v[1] && robf >= 2 && freeof(fp[1]) >= need) ? 1 : 0;
    chk("R2 fire0", int'(o_fire[0]), e_f0);
    chk("R3 R4 R5 fire1", int'(o_fire[1]), e_f1);
    chk("R6 tag0", int'(o_tag[0]), int'(tail));
    chk("R6 tag1", int'(o_tag[1]), (int'(tail) + 1) % DEPTH);
    for (int s = 0; s < 2; s++) begin
      exp_src(s, int'(sa[s]), rdy, tg);
      chk($sformatf("R7 R8 slot%0d a_ready", s), int'(o_ar[s]), rdy);
      chk($sformatf("R7 R8 slot%0d a_tag", s), int'(o_at[s]), tg);
      exp_src(s, int'(sb[s]), rdy, tg);
      chk($sformatf("R7 R8 slot%0d b_ready", s), int'(o_br[s]), rdy);
      chk($sformatf("R7 R8 slot%0d b_tag", s), int'(o_bt[s]), tg);
    end
    @(posedge clk);
    if (flush) clear_model();
    else begin
      if (e_f0 == 1 && hd[0]) begin busy[fp[0]][dst[0]] = 1; mtag[fp[0]][dst[0]] = int'(tail); end
      if (e_f1 == 1 && hd[1]) begin busy[fp[1]][dst[1]] = 1; mtag[fp[1]][dst[1]] = (int'(tail) + 1) % DEPTH; end
    end
    @(negedge clk);
    tail = tail + 4'(e_f0 + e_f1);
  endtask

  task automatic pair(input logic [1:0] vv, input logic [1:0] ff, input logic [1:0] hh,
                      input int d0, input int d1, input int a0, input int b0,
                      input int a1, input int b1);
    v = vv; fp = ff; hd = hh;
    dst[0] = 3'(d0); dst[1] = 3'(d1);
    sa[0] = 3'(a0); sb[0] = 3'(b0); sa[1] = 3'(a1); sb[1] = 3'(b1);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL [watchdog] run did not finish: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    ctx = "R1 reset state";
    pair(2'b00, 2'b10, 2'b00, 0, 0, 1, 2, 3, 7);
    cycle();

    ctx = "R7 single int writer then read";
    pair(2'b01, 2'b00, 2'b01, 3, 0, 1, 2, 0, 0);
    cycle();
    pair(2'b01, 2'b00, 2'b00, 0, 0, 3, 3, 0, 0);
    cycle();

    ctx = "R8 int pair dependence";
    pair(2'b11, 2'b00, 2'b11, 4, 5, 0, 1, 4, 4);
    cycle();
    ctx = "R8 fp pair dependence";
    pair(2'b11, 2'b11, 2'b11, 2, 6, 0, 1, 1, 2);
    cycle();

    ctx = "R9 mixed pair no cross-check";
    pair(2'b11, 2'b10, 2'b11, 7, 1, 0, 0, 7, 7);
    cycle();
    ctx = "R9 fp lookup ignores int map";
    pair(2'b11, 2'b11, 2'b00, 0, 0, 3, 4, 5, 7);
    cycle();

    ctx = "R5 same class one station";
    rsi = 5'd1;
    pair(2'b11, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();
    ctx = "R5 mixed class one each";
    rsf = 5'd1;
    pair(2'b11, 2'b10, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();
    ctx = "R5 fp pair two stations";
    rsf = 5'd2;
    pair(2'b11, 2'b11, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();
    rsi = 5'd8; rsf = 5'd8;

    ctx = "R4 one reorder entry";
    robf = 5'd1;
    pair(2'b11, 2'b10, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();
    robf = 5'd0;
    ctx = "R2 no reorder entry";
    cycle();
    robf = 5'd16;

    ctx = "R3 blocked older slot";
    rsf = 5'd0;
    pair(2'b11, 2'b01, 2'b11, 2, 2, 0, 0, 0, 0);
    cycle();
    rsf = 5'd8;
    ctx = "R2 older slot empty";
    pair(2'b10, 2'b00, 2'b10, 0, 5, 0, 0, 0, 0);
    cycle();

    ctx = "R6 tail wrap";
    tail = 4'd15;
    pair(2'b11, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();

    ctx = "R10 both write same register";
    pair(2'b11, 2'b00, 2'b11, 6, 6, 0, 0, 1, 1);
    cycle();
    pair(2'b11, 2'b00, 2'b00, 0, 0, 6, 6, 6, 6);
    cycle();

    ctx = "R12 blocked writer leaves map";
    rsi = 5'd0;
    pair(2'b01, 2'b00, 2'b01, 1, 0, 0, 0, 0, 0);
    cycle();
    rsi = 5'd8;
    pair(2'b01, 2'b00, 2'b00, 0, 0, 1, 1, 0, 0);
    cycle();

    ctx = "R13 no destination";
    pair(2'b01, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();
    pair(2'b01, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle();

    ctx = "R11 flush";
    flush = 1'b1;
    pair(2'b11, 2'b01, 2'b11, 3, 3, 3, 6, 6, 2);
    cycle();
    flush = 1'b0;
    pair(2'b00, 2'b01, 2'b00, 0, 0, 3, 6, 4, 2);
    cycle();
    pair(2'b00, 2'b00, 2'b00, 0, 0, 3, 6, 4, 2);
    cycle();

    ctx = "random R2 R7 R8 R10";
    for (int i = 0; i < 600; i++) begin
      v = 2'($urandom); fp = 2'($urandom); hd = 2'($urandom);
      dst = 6'($urandom); sa = 6'($urandom); sb = 6'($urandom);
      rsi = 5'($urandom_range(0, 3)); rsf = 5'($urandom_range(0, 3));
      robf = 5'($urandom_range(0, 3));
      flush = ($urandom_range(0, 31) == 0);
      cycle();
    end
    flush = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule